// File: doc/BRIEF.md
# Gamepad Input Register Bridge

The bridge lets a host processor read the button state of two gamepads as fixed, console-style pad words. Each player arrives as a 32-bit button bitmap from another clock domain. Each bitmap passes through a two-flop synchronizer. The low sixteen synchronized bits are then permuted into a 16-bit active-low word, in which a pressed button reads as a cleared bit.

The host uses a small word-addressed port. A read is a one-cycle `rd_en` with a 4-bit offset. The answer comes back one clock later, qualified by a single-cycle `rd_valid`. Offset 0 holds the player-one word, offset 1 the player-two word and offset 2 a constant status word. Every other offset reads zero. The write port exists only so the bus sees a complete slave: write strobes are accepted and change nothing.

Top module: `pad_word_bridge`

## Requirements
- R1: A change on a player bitmap, applied before clock edge e1, is first seen by a read whose `rd_en` is sampled at edge e3. Reads sampled at e1 and e2 still return the old word.
- R2: Offset 0 returns the player-one word and offset 1 the player-two word. Both are zero-extended to 32 bits.
- R3: Offset 2 always returns 0x0000_0001. Bit 0 set means the pad data is present and valid.
- R4: Offsets 3 through 15 return 0x0000_0000.
- R5: Pad words are active-low. With no button pressed a pad word reads 0x0000_FFFF, and every pressed mapped button clears exactly one bit.
- R6: Pad word bits 0 to 7 are taken inverted from input bits 5, 14, 15, 4, 3, 0, 2, 1 respectively.
- R7: Pad word bits 8 to 15 are taken inverted from input bits 12, 13, 10, 11, 6, 9, 7, 8 respectively.
- R8: Input bits 16 to 31, including the menu button at bit 16, never change either pad word.
- R9: A write strobe at any offset changes no read value. A read issued in the same cycle as a write still returns the normal value.
- R10: Each player's word depends only on that player's bitmap.
- R11: Reset is synchronous and active-high. While it is asserted, `rd_valid` stays low and `rd_data` is zero even if `rd_en` is high. After release, both pad words read 0x0000_FFFF until an input changes.
- R12: `rd_valid` is high for exactly one cycle, one clock after each cycle in which `rd_en` is sampled high. `rd_data` carries the answer in that cycle and is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p1_buttons | input | 32 | Player-one button bitmap, asynchronous, 1 = pressed |
| p2_buttons | input | 32 | Player-two button bitmap, asynchronous, 1 = pressed |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read word offset |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| wr_en | input | 1 | Write strobe (accepted, no effect) |
| wr_addr | input | 4 | Write word offset |
| wr_data | input | 32 | Write data |

## Verification
The permutation is driven first with a walking single button on each player. A swapped or uninverted source bit therefore shows up as one wrong bit at a known position. Complementary alternating patterns, 0x5555 on one player against 0xAAAA on the other, separate the two players and catch crossed player wiring. Patterns confined to bits 16 and up, including the menu bit, show that the upper half is dropped. An all-pressed low half reads 0x0000, which catches a missing inversion on any bit. A held read across an input change pins the synchronizer depth to exactly two flops.

// File: rtl/pad_bridge_pkg.sv
package pad_bridge_pkg;

    localparam int IN_W   = 32;
    localparam int PAD_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [DATA_W-1:0] STATUS_VALUE = 32'h0000_0001;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PLAYER1 = 4'd0,
        OFS_PLAYER2 = 4'd1,
        OFS_STATUS  = 4'd2
    } reg_ofs_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_resp_t;

    // Source input bit for each pad word bit (word bit k <- ~input[pad_src(k)]).
    function automatic int pad_src(input int k);
        case (k)
            0:  return 5;
            1:  return 14;
            2:  return 15;
            3:  return 4;
            4:  return 3;
            5:  return 0;
            6:  return 2;
            7:  return 1;
            8:  return 12;
            9:  return 13;
            10: return 10;
            11: return 11;
            12: return 6;
            13: return 9;
            14: return 7;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (sync_out == '0));
endmodule

// File: rtl/pad_word_remap.sv
module pad_word_remap
    import pad_bridge_pkg::*;
(
    input  logic [PAD_W-1:0] buttons,
    output logic [PAD_W-1:0] pad_word
);
    for (genvar k = 0; k < PAD_W; k++) begin : g_bit
        localparam int SRC = pad_src(k);
        assign pad_word[k] = ~buttons[SRC];
    end

    // R5
    always_comb begin
        released_all_ones_chk: assert (!(buttons == '0) || (pad_word == '1));
    end
endmodule

// File: rtl/pad_read_port.sv
module pad_read_port
    import pad_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAD_W-1:0]  p1_word,
    input  logic [PAD_W-1:0]  p2_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_resp_t resp_q;
    rd_resp_t resp_d;

    always_comb begin
        resp_d = '0;
        if (rd_en) begin
            resp_d.valid = 1'b1;
            case (rd_addr)
                OFS_PLAYER1: resp_d.data = {{(DATA_W-PAD_W){1'b0}}, p1_word};
                OFS_PLAYER2: resp_d.data = {{(DATA_W-PAD_W){1'b0}}, p2_word};
                OFS_STATUS:  resp_d.data = STATUS_VALUE;
                default:     resp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign rd_data  = resp_q.data;
    assign rd_valid = resp_q.valid;

    // R12
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    // R12
    data_zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));
    // R3
    status_constant_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == OFS_STATUS) |=> (rd_data == STATUS_VALUE));
    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr > OFS_STATUS) |=> (rd_data == '0));
    // R11
    quiet_in_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/pad_word_bridge.sv
module pad_word_bridge
    import pad_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   p1_buttons,
    input  logic [IN_W-1:0]   p2_buttons,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int PLAYERS = 2;

    logic [PLAYERS-1:0][IN_W-1:0]  raw_in;
    logic [PLAYERS-1:0][IN_W-1:0]  synced;
    logic [PLAYERS-1:0][PAD_W-1:0] words;

    assign raw_in[0] = p1_buttons;
    assign raw_in[1] = p2_buttons;

    for (genvar p = 0; p < PLAYERS; p++) begin : g_player
        pad_sync #(.WIDTH(IN_W), .STAGES(2)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[p]),
            .sync_out (synced[p])
        );
        pad_word_remap u_remap (
            .buttons  (synced[p][PAD_W-1:0]),
            .pad_word (words[p])
        );

        // R8
        upper_bits_dropped_chk: assert property (@(posedge clk) disable iff (rst)
            ($stable(synced[p][PAD_W-1:0]) && !$stable(synced[p][IN_W-1:PAD_W]))
                |-> $stable(words[p]));
    end

    pad_read_port u_read (
        .clk      (clk),
        .rst      (rst),
        .p1_word  (words[0]),
        .p2_word  (words[1]),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R10
    players_independent_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(synced[1]) |-> $stable(words[1]));

    // R9
    write_strobe_known_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$isunknown({wr_addr, wr_data}));
endmodule

// File: tb/pad_word_bridge_test.sv
`timescale 1ns/1ps
module pad_word_bridge_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] p1_buttons, p2_buttons;
    logic        rd_en;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;

    always #2 clk = ~clk;

    pad_word_bridge uut (
        .clk(clk), .rst(rst), .p1_buttons(p1_buttons), .p2_buttons(p2_buttons),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // stimulus p1, p2 ; expected word1, word2
    localparam int NV = 7;
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0000, 32'h0000_0000, 16'hFFFF, 16'hFFFF},
        {32'h0000_0001, 32'h0000_8000, 16'hFFDF, 16'hFFFB},
        {32'h0001_0000, 32'hFFFF_0000, 16'hFFFF, 16'hFFFF},
        {32'h0000_FFFF, 32'h0000_0030, 16'h0000, 16'hFFF6},
        {32'h0000_00C0, 32'h0000_0300, 16'hAFFF, 16'h5FFF},
        {32'hAAAA_5555, 32'h5555_AAAA, 16'h6A95, 16'h956A},
        {32'hFFFF_FFFF, 32'h0001_0001, 16'h0000, 16'hFFDF}
    };

    // destination pad bit for each input bit 0..15
    function automatic logic [15:0] model_word(input logic [31:0] b);
        int dst [16] = '{5, 7, 6, 4, 3, 0, 12, 14, 15, 13, 10, 11, 8, 9, 1, 2};
        logic [15:0] w = 16'hFFFF;
        for (int i = 0; i < 16; i++) if (b[i]) w[dst[i]] = 1'b0;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        do_read(a, d, v);
        check({req, " valid"}, {31'd0, v}, 32'd1);
        check(req, d, exp);
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        p1_buttons = a;
        p2_buttons = b;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        logic v;
        rst = 1'b1; rd_en = 1'b0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        p1_buttons = 32'h0000_0FFF; p2_buttons = 32'h0000_0FFF;
        repeat (3) @(negedge clk);
        // R11: read during reset stays silent
        do_read(4'd2, d, v);
        check("R11 valid in reset", {31'd0, v}, 32'd0);
        check("R11 data in reset", d, 32'd0);
        p1_buttons = '0; p2_buttons = '0;
        rst = 1'b0;
        // R11: first post-reset reads show released pads
        read_check("R11 p1 after reset", 4'd0, 32'h0000_FFFF);
        read_check("R11 p2 after reset", 4'd1, 32'h0000_FFFF);
        // R12: single-cycle pulse, zero data after
        @(negedge clk);
        check("R12 valid drops", {31'd0, rd_valid}, 32'd0);
        check("R12 data idle zero", rd_data, 32'd0);
        // R3, R4
        read_check("R3 status", 4'd2, 32'h0000_0001);
        read_check("R4 offset 3", 4'd3, 32'd0);
        read_check("R4 offset 15", 4'd15, 32'd0);

        // R2 R5 R8 R10: vector table
        for (int n = 0; n < NV; n++) begin
            apply(VEC[n][95:64], VEC[n][63:32]);
            read_check($sformatf("R2 vec%0d p1", n), 4'd0, {16'd0, VEC[n][31:16]});
            read_check($sformatf("R10 vec%0d p2", n), 4'd1, {16'd0, VEC[n][15:0]});
        end

        // R6 R7: walking single button on each player
        for (int i = 0; i < 16; i++) begin
            apply(32'd1 << i, 32'd1 << (15 - i));
            read_check($sformatf(i < 8 ? "R6 walk p1 bit%0d" : "R7 walk p1 bit%0d", i),
                       4'd0, {16'd0, model_word(32'd1 << i)});
            read_check($sformatf("R10 walk p2 bit%0d", 15 - i),
                       4'd1, {16'd0, model_word(32'd1 << (15 - i))});
        end

        // R8: upper bits alone, incl. menu bit
        apply(32'hFFFF_0000, 32'h0001_0000);
        read_check("R8 p1 upper", 4'd0, 32'h0000_FFFF);
        read_check("R8 p2 menu", 4'd1, 32'h0000_FFFF);

        // R9: writes everywhere, then a write together with a read
        apply(32'h0000_0021, 32'h0000_4000);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = a[3:0]; wr_data = 32'hDEAD_0000 | a;
        end
        @(negedge clk);
        wr_en = 1'b0;
        read_check("R9 p1 after writes", 4'd0, {16'd0, model_word(32'h21)});
        read_check("R9 p2 after writes", 4'd1, {16'd0, model_word(32'h4000)});
        read_check("R9 status after writes", 4'd2, 32'h0000_0001);
        read_check("R9 offset 5 after writes", 4'd5, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h1234_5678;
        rd_en = 1'b1; rd_addr = 4'd0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 read with write", rd_data, {16'd0, model_word(32'h21)});

        // R1: hold a read across an input change
        apply(32'd0, 32'd0);
        @(negedge clk);
        p1_buttons = 32'h0000_0010;
        rd_en = 1'b1; rd_addr = 4'd0;
        @(negedge clk);
        check("R1 edge1 old", rd_data, 32'h0000_FFFF);
        @(negedge clk);
        check("R1 edge2 old", rd_data, 32'h0000_FFFF);
        @(negedge clk);
        check("R1 edge3 new", rd_data, {16'd0, model_word(32'h10)});
        check("R12 back-to-back valid", {31'd0, rd_valid}, 32'd1);
        rd_en = 1'b0;
        @(negedge clk);
        check("R12 valid ends", {31'd0, rd_valid}, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule